// File: doc/BRIEF.md
# Feed-Forward Frequency Acquisition Controller

This block chooses the control code of a digitally tuned oscillator so that the oscillator's edge count, taken over one reference half period, lands on half of the programmed divide ratio. It takes one step for each strobe from the edge counter. It tries the centre of the code range first, then a code a fixed distance above or below the centre. From these two code/count pairs it estimates a gain in codes per count, as a fixed-point value with 1/16 resolution. It then jumps straight to the code that this gain predicts. It keeps correcting that prediction until the count hits the target.

Once the count matches, the block drops its acquisition-mode enable and raises its lock flag. The oscillator code is then held for a downstream phase loop. If the phase error reported to the block grows too large, it starts the whole search again from the centre code.

Top module: `ffa_lock_ctrl`

## Requirements
- R1: Out of reset the code output is CODE_MAX/2 (157 with defaults), the acquisition enable is 1 and the lock flag is 0.
- R2: While the count strobe is low, the code, enable and lock outputs do not change, whatever the other inputs do.
- R3: The target count is the divide ratio shifted right by one bit, so odd ratios round down. A strobe whose count equals the target moves the block into tracking from any acquisition state. The code is unchanged, enable becomes 0 and lock becomes 1, all on the clock edge that samples the strobe.
- R4: On the first strobe after reset, or after a restart, a missed count sets the code to centre−STEP when the count is above target and to centre+STEP when it is below. STEP is 32 by default.
- R5: A strobe in the second step whose count equals the target enters tracking and keeps the second code.
- R6: On the second miss, the gain G is min(floor(16·|Δcode|/|Δcount|), 511) over the two steps. When Δcount is 0, G is 511. The new code is code + floor((G·(target−count) + 8)/16).
- R7: On each later miss the same prediction is used with the stored gain. The gain is first halved (shift right by one) when the count lies on the other side of the target from the previous miss.
- R8: A missed step always moves the code by at least one toward the target: up when the count is below target, down when it is above. The only exception is when the code is already at the range limit.
- R9: Every code is clamped to the range 0 to CODE_MAX (315).
- R10: In tracking, a strobe with a signed phase error whose magnitude exceeds 63 returns the block to the first step with the code at centre, enable 1 and lock 0. A magnitude of 63 or less leaves tracking and the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Edge count captured over the last reference half period |
| cnt_vld_i | input | 1 | One-cycle strobe: a new count (and phase error) is present |
| ratio_i | input | CNT_W+1 | Programmed divide ratio; the target count is half of it |
| phase_err_i | input | PE_W | Signed digitized phase error, used while tracking |
| code_o | output | CODE_W | Oscillator control code |
| acq_en_o | output | 1 | High while frequency acquisition is running |
| lock_o | output | 1 | High once the frequency is locked and tracking runs |

## Verification
The bench goes after the edges of the gain estimate. An unchanged count gives a zero divisor, which must saturate the gain. Without that, the design would divide by zero and jump to a wrong code instead of the range limit. A tiny gain must still move the code by one step; if it does not, the search stalls forever at the same code. The bench also alternates the side of the target to check that the gain is halved at the right time; if it is not, the code would overshoot and oscillate instead of settling. Negative predictions must round with floor semantics, which exposes off-by-one codes. The tracking exit is tested at magnitudes 63 and 64 with both signs, because a design that compares without the sign, or uses >= in place of >, restarts at the wrong error.

// File: rtl/ffa_pkg.sv
package ffa_pkg;

   typedef enum logic [1:0] {
      ST_CENTER  = 2'd0,
      ST_OFFSET  = 2'd1,
      ST_PREDICT = 2'd2,
      ST_TRACK   = 2'd3
   } ffa_state_e;

endpackage

// File: rtl/ffa_gain_div.sv
// Fixed-point gain divider: integer part by parallel multiple compare,
// fractional part by the same compare on the scaled remainder.
module ffa_gain_div #(
   parameter int A_W  = 9,
   parameter int B_W  = 10,
   parameter int KI_W = 5,
   parameter int KF_W = 4
) (
   input  logic [A_W-1:0]       dividend_i,
   input  logic [B_W-1:0]       divisor_i,
   output logic [KI_W+KF_W-1:0] gain_o
);
   localparam int QI_MAX = (1 << KI_W) - 1;
   localparam int QF_MAX = (1 << KF_W) - 1;
   localparam int WW     = A_W + B_W + KI_W + KF_W + 1;

   if (KI_W < 1 || KF_W < 1) begin : g_chk_w
      $error("gain divider needs integer and fraction bits");
   end

   logic [WW-1:0]     a_w, b_w, rem_w, rem_s;
   logic [QI_MAX-1:0] int_ge;
   logic [QF_MAX-1:0] frac_ge;
   logic [KI_W-1:0]   q_int;
   logic [KF_W-1:0]   q_frac;
   logic              sat;

   assign a_w = WW'(dividend_i);
   assign b_w = WW'(divisor_i);

   for (genvar gi = 1; gi <= QI_MAX; gi++) begin : g_int
      assign int_ge[gi-1] = (a_w >= WW'(gi) * b_w);
   end
   assign q_int = KI_W'($countones(int_ge));

   assign rem_w = a_w - WW'(q_int) * b_w;
   assign rem_s = rem_w << KF_W;

   for (genvar gf = 1; gf <= QF_MAX; gf++) begin : g_frac
      assign frac_ge[gf-1] = (rem_s >= WW'(gf) * b_w);
   end
   assign q_frac = KF_W'($countones(frac_ge));

   assign sat    = (divisor_i == '0) || (a_w >= WW'(QI_MAX + 1) * b_w);
   assign gain_o = sat ? '1 : {q_int, q_frac};

endmodule

// File: rtl/ffa_code_pred.sv
// Code predictor: code + round(gain * err), forced minimum step, clamp.
module ffa_code_pred #(
   parameter int CODE_W        = 9,
   parameter int CODE_MAX      = 315,
   parameter int ERR_W         = 11,
   parameter int KW            = 9,
   parameter int KF_W          = 4,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic [CODE_W-1:0]       code_i,
   input  logic [KW-1:0]           gain_i,
   input  logic signed [ERR_W-1:0] err_i,
   output logic [CODE_W-1:0]       code_o
);
   localparam int PW = KW + ERR_W + 1;
   localparam int SW = PW + 2;
   localparam logic signed [SW-1:0] MAX_S = SW'(CODE_MAX);

   if (SW <= CODE_W + 1) begin : g_chk_sw
      $error("predictor sum too narrow");
   end

   logic signed [PW-1:0] prod, scaled, step;
   logic signed [SW-1:0] sum;

   assign prod = $signed({1'b0, gain_i}) * err_i;

   if (ROUND_NEAREST) begin : g_round_near
      localparam logic signed [PW-1:0] HALF = PW'(1 << (KF_W - 1));
      assign scaled = (prod + HALF) >>> KF_W;
   end else begin : g_round_floor
      assign scaled = prod >>> KF_W;
   end

   always_comb begin
      if (scaled == '0) begin
         step = err_i[ERR_W-1] ? {PW{1'b1}} : PW'(1);
      end else begin
         step = scaled;
      end
      sum = SW'(step) + $signed({{(SW-CODE_W){1'b0}}, code_i});
      if (sum < 0) begin
         code_o = '0;
      end else if (sum > MAX_S) begin
         code_o = CODE_W'(CODE_MAX);
      end else begin
         code_o = sum[CODE_W-1:0];
      end
   end

endmodule

// File: rtl/ffa_lock_ctrl.sv
module ffa_lock_ctrl
   import ffa_pkg::*;
#(
   parameter int CNT_W         = 10,
   parameter int CODE_W        = 9,
   parameter int CODE_MAX      = 315,
   parameter int STEP          = 32,
   parameter int KI_W          = 5,
   parameter int KF_W          = 4,
   parameter int PE_W          = 10,
   parameter int PE_LIMIT      = 63,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W-1:0]       cnt_i,
   input  logic                   cnt_vld_i,
   input  logic [CNT_W:0]         ratio_i,
   input  logic signed [PE_W-1:0] phase_err_i,
   output logic [CODE_W-1:0]      code_o,
   output logic                   acq_en_o,
   output logic                   lock_o
);
   localparam int KW    = KI_W + KF_W;
   localparam int ERR_W = CNT_W + 1;
   localparam int MID   = CODE_MAX / 2;
   localparam logic [CODE_W-1:0] CODE_MID_C = CODE_W'(MID);
   localparam logic [CODE_W-1:0] CODE_UP_C  = CODE_W'(MID + STEP);
   localparam logic [CODE_W-1:0] CODE_DN_C  = CODE_W'(MID - STEP);
   localparam logic signed [PE_W-1:0] PE_HI = PE_W'(PE_LIMIT);
   localparam logic signed [PE_W-1:0] PE_LO = -PE_HI;

   if (CODE_MAX >= (1 << CODE_W)) begin : g_chk_code
      $error("CODE_MAX does not fit CODE_W");
   end
   if (STEP < 1 || STEP > MID || MID + STEP > CODE_MAX) begin : g_chk_step
      $error("STEP must keep the second code inside the range");
   end
   if (PE_LIMIT < 0 || PE_LIMIT >= (1 << (PE_W - 1)) - 1) begin : g_chk_pe
      $error("PE_LIMIT does not fit PE_W");
   end

   ffa_state_e               state_q;
   logic [CODE_W-1:0]        code_q, prev_code_q, code_pred;
   logic [CNT_W-1:0]         prev_cnt_q;
   logic [KW-1:0]            k_q, k_div, k_upd, k_pred;
   logic                     above_q;
   logic [CNT_W:0]           half_ratio;
   logic signed [ERR_W-1:0]  err;
   logic                     hit, above, pe_big;
   logic [CODE_W-1:0]        dcode;
   logic [CNT_W-1:0]         dcnt;

   // target count and error
   assign half_ratio = ratio_i >> 1;
   assign hit        = ({1'b0, cnt_i} == half_ratio);
   assign above      = ({1'b0, cnt_i} > half_ratio);
   assign err        = $signed(half_ratio) - $signed({1'b0, cnt_i});
   assign pe_big     = (phase_err_i > PE_HI) || (phase_err_i < PE_LO);

   // two-point slope operands
   assign dcode = (code_q >= prev_code_q) ? code_q - prev_code_q : prev_code_q - code_q;
   assign dcnt  = (cnt_i >= prev_cnt_q) ? cnt_i - prev_cnt_q : prev_cnt_q - cnt_i;

   ffa_gain_div #(
      .A_W (CODE_W),
      .B_W (CNT_W),
      .KI_W(KI_W),
      .KF_W(KF_W)
   ) u_div (
      .dividend_i(dcode),
      .divisor_i (dcnt),
      .gain_o    (k_div)
   );

   // gain halves when the count crosses to the other side of the target
   assign k_upd  = (above != above_q) ? (k_q >> 1) : k_q;
   assign k_pred = (state_q == ST_OFFSET) ? k_div : k_upd;

   ffa_code_pred #(
      .CODE_W       (CODE_W),
      .CODE_MAX     (CODE_MAX),
      .ERR_W        (ERR_W),
      .KW           (KW),
      .KF_W         (KF_W),
      .ROUND_NEAREST(ROUND_NEAREST)
   ) u_pred (
      .code_i(code_q),
      .gain_i(k_pred),
      .err_i (err),
      .code_o(code_pred)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_CENTER;
         code_q      <= CODE_MID_C;
         prev_code_q <= CODE_MID_C;
         prev_cnt_q  <= '0;
         k_q         <= '0;
         above_q     <= 1'b0;
      end else if (cnt_vld_i) begin
         unique case (state_q)
            ST_CENTER: begin
               if (hit) begin
                  state_q <= ST_TRACK;
               end else begin
                  prev_code_q <= code_q;
                  prev_cnt_q  <= cnt_i;
                  code_q      <= above ? CODE_DN_C : CODE_UP_C;
                  state_q     <= ST_OFFSET;
               end
            end
            ST_OFFSET, ST_PREDICT: begin
               if (hit) begin
                  state_q <= ST_TRACK;
               end else begin
                  prev_code_q <= code_q;
                  prev_cnt_q  <= cnt_i;
                  code_q      <= code_pred;
                  k_q         <= k_pred;
                  above_q     <= above;
                  state_q     <= ST_PREDICT;
               end
            end
            ST_TRACK: begin
               if (pe_big) begin
                  state_q <= ST_CENTER;
                  code_q  <= CODE_MID_C;
               end
            end
         endcase
      end
   end

   assign code_o   = code_q;
   assign acq_en_o = (state_q != ST_TRACK);
   assign lock_o   = (state_q == ST_TRACK);

endmodule

// File: rtl/ffa_lock_ctrl_chk.sv
module ffa_lock_ctrl_chk #(
   parameter int CNT_W    = 10,
   parameter int CODE_W   = 9,
   parameter int CODE_MAX = 315,
   parameter int PE_W     = 10,
   parameter int PE_LIMIT = 63
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [CNT_W-1:0]       cnt_i,
   input logic                   cnt_vld_i,
   input logic [CNT_W:0]         ratio_i,
   input logic signed [PE_W-1:0] phase_err_i,
   input logic [CODE_W-1:0]      code_o,
   input logic                   acq_en_o,
   input logic                   lock_o
);
   localparam logic signed [PE_W-1:0] HI_C = PE_W'(PE_LIMIT);
   localparam logic signed [PE_W-1:0] LO_C = -HI_C;
   localparam logic [CODE_W-1:0] TOP_C = CODE_W'(CODE_MAX);
   localparam logic [CODE_W-1:0] MID_C = CODE_W'(CODE_MAX / 2);

   logic [CNT_W:0] goal;
   logic           big_err;
   assign goal    = ratio_i >> 1;
   assign big_err = (phase_err_i > HI_C) || (phase_err_i < LO_C);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_vld_i |=> ($stable(code_o) && $stable(acq_en_o) && $stable(lock_o)));

   // R9
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_o <= TOP_C);

   // R3
   lock_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_en_o && cnt_vld_i && ({1'b0, cnt_i} == goal))
      |=> (lock_o && !acq_en_o && $stable(code_o)));

   // R4
   miss_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_en_o && cnt_vld_i && ({1'b0, cnt_i} != goal)) |=> (acq_en_o && !lock_o));

   // R8
   rise_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_en_o && cnt_vld_i && ({1'b0, cnt_i} < goal) && (code_o < TOP_C))
      |=> (code_o > $past(code_o)));

   // R8
   fall_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_en_o && cnt_vld_i && ({1'b0, cnt_i} > goal) && (code_o != '0))
      |=> (code_o < $past(code_o)));

   // R10
   track_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && cnt_vld_i && big_err) |=> (acq_en_o && !lock_o && code_o == MID_C));

   // R10
   track_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && cnt_vld_i && !big_err) |=> (lock_o && $stable(code_o)));

endmodule

bind ffa_lock_ctrl ffa_lock_ctrl_chk #(
   .CNT_W   (CNT_W),
   .CODE_W  (CODE_W),
   .CODE_MAX(CODE_MAX),
   .PE_W    (PE_W),
   .PE_LIMIT(PE_LIMIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cnt_i      (cnt_i),
   .cnt_vld_i  (cnt_vld_i),
   .ratio_i    (ratio_i),
   .phase_err_i(phase_err_i),
   .code_o     (code_o),
   .acq_en_o   (acq_en_o),
   .lock_o     (lock_o)
);

// File: tb/ffa_lock_ctrl_test.sv
module ffa_lock_ctrl_test;
   localparam int CNT_W  = 10;
   localparam int CODE_W = 9;
   localparam int PE_W   = 10;
   localparam int CMAX   = 315;
   localparam int MID    = 157;
   localparam int STEP   = 32;
   localparam int KMAX   = 511;
   localparam int WD_LIM = 150000;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic [CNT_W-1:0]       cnt_i;
   logic                   cnt_vld_i;
   logic [CNT_W:0]         ratio_i;
   logic signed [PE_W-1:0] phase_err_i;
   logic [CODE_W-1:0]      code_o;
   logic                   acq_en_o;
   logic                   lock_o;

   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;

   int m_state, m_code, m_pcode, m_pcnt, m_k;
   bit m_above;

   always #4 clk = ~clk;

   ffa_lock_ctrl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_i      (cnt_i),
      .cnt_vld_i  (cnt_vld_i),
      .ratio_i    (ratio_i),
      .phase_err_i(phase_err_i),
      .code_o     (code_o),
      .acq_en_o   (acq_en_o),
      .lock_o     (lock_o)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIM) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cyc, WD_LIM);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   function automatic int abs_i(int v);
      return (v < 0) ? -v : v;
   endfunction

   // R6: gain = min(floor(16*a/b), 511), zero divisor saturates
   function automatic int gain_ref(int a, int b);
      int q;
      if (b == 0) return KMAX;
      q = (a * 16) / b;
      return (q > KMAX) ? KMAX : q;
   endfunction

   // R6, R8, R9: floor((G*err+8)/16), minimum one step, clamp
   function automatic int pred_ref(int code, int g, int e);
      int d, n;
      d = (g * e + 8) >>> 4;
      if (d == 0) d = (e < 0) ? -1 : 1;
      n = code + d;
      if (n < 0) n = 0;
      if (n > CMAX) n = CMAX;
      return n;
   endfunction

   task automatic model_reset();
      m_state = 0; m_code = MID; m_pcode = MID; m_pcnt = 0; m_k = 0; m_above = 1'b0;
   endtask

   task automatic model_step(int cnt, int ratio, int pe);
      int tgt;
      bit hit, abv;
      tgt = ratio >> 1;
      hit = (cnt == tgt);
      abv = (cnt > tgt);
      case (m_state)
         0: if (hit) m_state = 3;
            else begin
               m_pcode = m_code; m_pcnt = cnt;
               m_code = abv ? MID - STEP : MID + STEP;
               m_state = 1;
            end
         1: if (hit) m_state = 3;
            else begin
               m_k = gain_ref(abs_i(m_code - m_pcode), abs_i(cnt - m_pcnt));
               m_pcode = m_code; m_pcnt = cnt;
               m_code = pred_ref(m_code, m_k, tgt - cnt);
               m_above = abv; m_state = 2;
            end
         2: if (hit) m_state = 3;
            else begin
               if (abv != m_above) m_k = m_k >> 1;
               m_pcode = m_code; m_pcnt = cnt;
               m_code = pred_ref(m_code, m_k, tgt - cnt);
               m_above = abv;
            end
         default: if (abs_i(pe) > 63) begin
               m_state = 0; m_code = MID;
            end
      endcase
   endtask

   task automatic check_out(string req);
      bit exp_acq, exp_lock;
      exp_acq  = (m_state != 3);
      exp_lock = (m_state == 3);
      n_vec++;
      if (int'(code_o) != m_code || acq_en_o != exp_acq || lock_o != exp_lock) begin
         n_bad++;
         $display("FAIL %s: actual code=%0d acq=%0b lock=%0b expected code=%0d acq=%0b lock=%0b",
                  req, code_o, acq_en_o, lock_o, m_code, exp_acq, exp_lock);
      end
   endtask

   task automatic expect_code(int exp, string req);
      n_vec++;
      if (int'(code_o) != exp) begin
         n_bad++;
         $display("FAIL %s: actual code=%0d expected code=%0d", req, code_o, exp);
      end
   endtask

   task automatic step(int cnt, int ratio, int pe, string req);
      @(negedge clk);
      cnt_i       = CNT_W'(cnt);
      ratio_i     = (CNT_W + 1)'(ratio);
      phase_err_i = PE_W'(pe);
      cnt_vld_i   = 1'b1;
      @(negedge clk);
      cnt_vld_i = 1'b0;
      model_step(cnt, ratio, pe);
      check_out(req);
   endtask

   task automatic idle(int n, string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cnt_i       = CNT_W'($urandom);
         ratio_i     = (CNT_W + 1)'($urandom);
         phase_err_i = PE_W'($urandom);
         cnt_vld_i   = 1'b0;
      end
      @(negedge clk);
      check_out(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cnt_vld_i = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
   endtask

   initial begin
      int base, g16, tc, ratio, cnt, nz;
      void'($urandom(32'd20250611));
      rst_n = 1'b0; cnt_vld_i = 1'b0; cnt_i = '0; ratio_i = '0; phase_err_i = '0;
      model_reset();
      do_reset();
      @(negedge clk);
      check_out("R1");
      expect_code(157, "R1");

      // hit at the centre with an odd ratio (target 200), then tracking limits
      step(200, 401, 0, "R3");
      step(0, 401, 63, "R10 hold at 63");
      step(0, 401, -63, "R10 hold at -63");
      idle(4, "R2 while tracking");
      step(0, 401, -64, "R10 exit at -64");
      expect_code(157, "R10");

      // hit on the second code
      step(150, 400, 0, "R4 below target");
      expect_code(189, "R4");
      step(200, 400, 0, "R5");
      expect_code(189, "R5");
      step(0, 400, 64, "R10 exit at 64");
      step(250, 400, 0, "R4 above target");
      expect_code(125, "R4");

      // gain estimate, crossing, refinement
      do_reset();
      step(150, 400, 0, "R4");
      step(170, 400, 0, "R6 predict");
      expect_code(236, "R6");
      step(205, 400, 0, "R7 crossing halves gain");
      expect_code(232, "R7");
      step(201, 400, 0, "R7 same side");
      expect_code(231, "R7");
      idle(5, "R2 during search");
      step(200, 400, 0, "R3 lock in predict");
      expect_code(231, "R3");

      // zero count change saturates gain, clamp at both ends
      do_reset();
      step(150, 400, 0, "R4");
      step(150, 400, 0, "R9 clamp high");
      expect_code(315, "R9");
      step(250, 400, 0, "R9 clamp low");
      expect_code(0, "R9");

      // gain rounds to zero: forced single step
      do_reset();
      step(150, 400, 0, "R4");
      step(1000, 400, 0, "R8 minimum step");
      expect_code(188, "R8");
      step(1000, 400, 0, "R8 minimum step again");
      expect_code(187, "R8");

      // random oscillator models
      do_reset();
      for (int t = 0; t < 250; t++) begin
         base  = 20 + ($urandom % 180);
         g16   = 4 + ($urandom % 29);
         tc    = $urandom % (CMAX + 1);
         ratio = 2 * (base + (tc * g16) / 16) + ($urandom % 2);
         if (m_state == 3) step(0, ratio, 100 + ($urandom % 300), "R10 restart");
         for (int s = 0; s < 30 && m_state != 3; s++) begin
            nz  = (($urandom % 4) == 0) ? (int'($urandom % 3) - 1) : 0;
            cnt = base + (m_code * g16) / 16 + nz;
            if (cnt < 0) cnt = 0;
            if (cnt > 1023) cnt = 1023;
            step(cnt, ratio, 0, "R6/R7 search");
         end
         for (int p = 0; p < 3; p++) begin
            step($urandom % 1024, ratio, int'($urandom % 181) - 90, "R10 random");
         end
         if (($urandom % 8) == 0) idle(2, "R2 random idle");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule